// File: doc/BRIEF.md
# Lockstep Counter Phase Capture Averager

This block measures where a square-wave reference falls within each half-cycle of a locally synthesized wave. A mirror counter is kept in lockstep with the counter that produces the output wave. It shares the same clock, the same reload value, the same wrap rule and the same start edge, so its count at any moment equals the output counter's count. Every transition of the reference is first passed through a synchronizer. Both rising and falling transitions then capture the mirror count, and that captured count is the phase reading.

Single readings are noisy. On every half-cycle tick the most recent capture is written into a circular history, provided recording is enabled. The history holds 1250 entries by default. Once per action period a strobe asks for a result. The block divides the running sum of the whole history by its depth with a sequential divider, then presents the average together with the signed change from the previous average. A surrounding control loop uses the change to correct frequency and the average to correct phase. The action period is set outside the block: 120000 ticks gives one second, 240000 gives two seconds and 12000 gives a tenth of a second.

Top module: `phase_capture_avg`

## Requirements
- R1: While reset is held, and on the first cycle after it, `phase_cap`, `avg_out` and `avg_diff` are zero and `avg_valid` is low. Every history entry, and the previous average, also start at zero.
- R2: While `run` is low, the mirror count is held at 0 and the wrap limit follows `reload_val`. On each clock edge with `run` high, the count wraps to 0 if it equals the limit, and the limit is then reloaded from `reload_val`; otherwise the count increments by 1.
- R3: `ref_in` passes through two synchronizing flops. Either kind of transition causes a capture. The captured value is the mirror count that stands after the second clock edge following the input change, and it appears on `phase_cap` after the third edge.
- R4: On a clock edge with `hc_tick` and `rec_en` both high, the current `phase_cap` is written at the history pointer. The pointer then advances, and it wraps to 0 after the last entry, HIST_DEPTH-1. A tick with `rec_en` low writes nothing, so the next average is unchanged.
- R5: An `act_stb` accepted while idle starts a division of the sum of all HIST_DEPTH entries by HIST_DEPTH. When the division completes, `avg_out` takes the floor of the quotient and `avg_valid` pulses for exactly one cycle. `avg_out` changes at no other time.
- R6: With each `avg_valid`, `avg_diff` equals the new average minus the previous average, as a two's-complement value one bit wider than the count. The new average then becomes the previous one.
- R7: An `act_stb` that arrives while a division is in progress is ignored. The running division is not restarted and produces exactly one `avg_valid`.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the output counter |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter enable; its rising edge starts the mirror count |
| reload_val | input | CNT_W | Wrap limit, loaded at start and at each wrap |
| ref_in | input | 1 | Asynchronous reference square wave |
| hc_tick | input | 1 | One pulse per half-cycle of the output wave |
| rec_en | input | 1 | Enables writes into the history |
| act_stb | input | 1 | Requests a new average |
| phase_cap | output | CNT_W | Most recent captured mirror count |
| avg_out | output | CNT_W | Average of the history |
| avg_diff | output | CNT_W+1 | Signed change of the average since the previous result |
| avg_valid | output | 1 | One-cycle pulse when a new average is presented |

## Verification
The bench drives reference transitions spaced so that some captures land just before a wrap and some just after it. It also changes the reload value mid-run. An off-by-one in synchronizer latency, or a limit sampled at the wrong moment, would then show up as a captured count that is wrong by one or more. The history is filled past its depth so that the average must drop the oldest entries; a pointer that wraps one entry late, or a running sum that forgets to subtract the overwritten value, would produce a wrong average. Ticks with recording disabled, and a strobe repeated during a division, target writes that leak through and divisions that restart; these would appear as a shifted average, a nonzero change or a second valid pulse.

// File: rtl/phase_avg_pkg.sv
package phase_avg_pkg;

    localparam int CNT_W_DEF      = 12;
    localparam int HIST_DEPTH_DEF = 1250;

    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_DONE = 2'd2
    } div_state_t;

    function automatic int sum_bits(input int depth, input int cw);
        return cw + $clog2(depth);
    endfunction

    function automatic int step_bits(input int sw);
        return (sw < 2) ? 1 : $clog2(sw);
    endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic any_edge
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign any_edge = sync_q ^ last_q;
endmodule

// File: rtl/mirror_counter.sv
module mirror_counter #(
    parameter int CNT_W = phase_avg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            limit <= '0;
        end else if (!run) begin
            count <= '0;
            limit <= reload_val;
        end else if (count == limit) begin
            count <= '0;
            limit <= reload_val;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/phase_history.sv
module phase_history #(
    parameter int CNT_W      = phase_avg_pkg::CNT_W_DEF,
    parameter int HIST_DEPTH = phase_avg_pkg::HIST_DEPTH_DEF,
    parameter int SUM_W      = phase_avg_pkg::sum_bits(HIST_DEPTH, CNT_W),
    parameter int PTR_W      = (HIST_DEPTH < 2) ? 1 : $clog2(HIST_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [SUM_W-1:0] run_sum
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(HIST_DEPTH - 1);

    logic [CNT_W-1:0] mem [HIST_DEPTH];
    logic [CNT_W-1:0] oldest;

    assign oldest = mem[wr_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST_DEPTH; i++) begin
                mem[i] <= '0;
            end
            wr_ptr  <= '0;
            run_sum <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            run_sum     <= run_sum + SUM_W'(wr_data) - SUM_W'(oldest);
            wr_ptr      <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int SUM_W   = 22,
    parameter int QUO_W   = 12,
    parameter int DIVISOR = phase_avg_pkg::HIST_DEPTH_DEF,
    parameter int STEP_W  = phase_avg_pkg::step_bits(SUM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SUM_W-1:0]  dividend,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] steps_left,
    output logic [QUO_W-1:0]  quotient
);
    import phase_avg_pkg::*;

    localparam int REM_W = $clog2(DIVISOR) + 1;
    localparam logic [REM_W:0] DIV_EXT = (REM_W + 1)'(DIVISOR);

    div_state_t       state;
    logic [SUM_W-1:0] dvd_q;
    logic [REM_W-1:0] rem_q;
    logic [REM_W:0]   trial;
    logic             fits;

    assign trial = {rem_q, dvd_q[SUM_W-1]};
    assign fits  = (trial >= DIV_EXT);
    assign busy  = (state != DIV_IDLE);
    assign done  = (state == DIV_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= DIV_IDLE;
            dvd_q      <= '0;
            rem_q      <= '0;
            steps_left <= '0;
            quotient   <= '0;
        end else begin
            case (state)
                DIV_IDLE: begin
                    if (start) begin
                        dvd_q      <= dividend;
                        rem_q      <= '0;
                        quotient   <= '0;
                        steps_left <= STEP_W'(SUM_W - 1);
                        state      <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    dvd_q <= dvd_q << 1;
                    if (fits) begin
                        rem_q    <= REM_W'(trial - DIV_EXT);
                        quotient <= {quotient[QUO_W-2:0], 1'b1};
                    end else begin
                        rem_q    <= REM_W'(trial);
                        quotient <= {quotient[QUO_W-2:0], 1'b0};
                    end
                    if (steps_left == '0) begin
                        state <= DIV_DONE;
                    end else begin
                        steps_left <= steps_left - 1'b1;
                    end
                end
                default: begin
                    state <= DIV_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/phase_capture_avg.sv
module phase_capture_avg #(
    parameter int CNT_W      = phase_avg_pkg::CNT_W_DEF,
    parameter int HIST_DEPTH = phase_avg_pkg::HIST_DEPTH_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [CNT_W-1:0]   reload_val,
    input  logic               ref_in,
    input  logic               hc_tick,
    input  logic               rec_en,
    input  logic               act_stb,
    output logic [CNT_W-1:0]   phase_cap,
    output logic [CNT_W-1:0]   avg_out,
    output logic signed [CNT_W:0] avg_diff,
    output logic               avg_valid
);
    import phase_avg_pkg::*;

    localparam int SUM_W  = sum_bits(HIST_DEPTH, CNT_W);
    localparam int PTR_W  = (HIST_DEPTH < 2) ? 1 : $clog2(HIST_DEPTH);
    localparam int STEP_W = step_bits(SUM_W);

    logic [CNT_W-1:0]  mir_cnt;
    logic [CNT_W-1:0]  mir_lim;
    logic              ref_edge;
    logic              hist_wr;
    logic [PTR_W-1:0]  hist_ptr;
    logic [SUM_W-1:0]  hist_sum;
    logic              div_busy;
    logic              div_done;
    logic [STEP_W-1:0] div_steps;
    logic [CNT_W-1:0]  div_quo;
    logic [CNT_W-1:0]  prev_avg;

    mirror_counter #(.CNT_W(CNT_W)) u_mirror (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .reload_val (reload_val),
        .count      (mir_cnt),
        .limit      (mir_lim)
    );

    ref_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_in),
        .any_edge (ref_edge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_cap <= '0;
        end else if (ref_edge) begin
            phase_cap <= mir_cnt;
        end
    end

    assign hist_wr = hc_tick & rec_en;

    phase_history #(
        .CNT_W      (CNT_W),
        .HIST_DEPTH (HIST_DEPTH),
        .SUM_W      (SUM_W),
        .PTR_W      (PTR_W)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hist_wr),
        .wr_data (phase_cap),
        .wr_ptr  (hist_ptr),
        .run_sum (hist_sum)
    );

    seq_divider #(
        .SUM_W   (SUM_W),
        .QUO_W   (CNT_W),
        .DIVISOR (HIST_DEPTH),
        .STEP_W  (STEP_W)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .start      (act_stb),
        .dividend   (hist_sum),
        .busy       (div_busy),
        .done       (div_done),
        .steps_left (div_steps),
        .quotient   (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            avg_out   <= '0;
            prev_avg  <= '0;
            avg_diff  <= '0;
            avg_valid <= 1'b0;
        end else begin
            avg_valid <= div_done;
            if (div_done) begin
                avg_out  <= div_quo;
                avg_diff <= $signed({1'b0, div_quo}) - $signed({1'b0, prev_avg});
                prev_avg <= div_quo;
            end
        end
    end
endmodule

// File: rtl/phase_capture_avg_chk.sv
module phase_capture_avg_chk #(
    parameter int CNT_W  = 12,
    parameter int PTR_W  = 11,
    parameter int STEP_W = 5,
    parameter int DEPTH  = 1250
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              hc_tick,
    input logic              rec_en,
    input logic              act_stb,
    input logic              ref_edge,
    input logic [CNT_W-1:0]  mir_cnt,
    input logic [CNT_W-1:0]  mir_lim,
    input logic [CNT_W-1:0]  phase_cap,
    input logic [PTR_W-1:0]  hist_ptr,
    input logic              div_busy,
    input logic [STEP_W-1:0] div_steps,
    input logic [CNT_W-1:0]  avg_out,
    input logic signed [CNT_W:0] avg_diff,
    input logic              avg_valid
);
    logic [CNT_W-1:0] seen_avg;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_avg <= '0;
        end else if (avg_valid) begin
            seen_avg <= avg_out;
        end
    end

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        mir_cnt <= mir_lim);

    // R2
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> mir_cnt == '0);

    // R3
    capture_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_edge |=> $stable(phase_cap));

    // R4
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        hist_ptr < PTR_W'(DEPTH));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(hc_tick && rec_en) |=> $stable(hist_ptr));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> !avg_valid);

    // R5
    avg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !avg_valid |-> $stable(avg_out));

    // R6
    diff_match_chk: assert property (@(posedge clk) disable iff (rst)
        avg_valid |-> avg_diff == ($signed({1'b0, avg_out}) - $signed({1'b0, seen_avg})));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (div_busy && act_stb && div_steps != '0) |=> div_steps == $past(div_steps) - 1'b1);
endmodule

bind phase_capture_avg phase_capture_avg_chk #(
    .CNT_W  (CNT_W),
    .PTR_W  (PTR_W),
    .STEP_W (STEP_W),
    .DEPTH  (HIST_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .hc_tick   (hc_tick),
    .rec_en    (rec_en),
    .act_stb   (act_stb),
    .ref_edge  (ref_edge),
    .mir_cnt   (mir_cnt),
    .mir_lim   (mir_lim),
    .phase_cap (phase_cap),
    .hist_ptr  (hist_ptr),
    .div_busy  (div_busy),
    .div_steps (div_steps),
    .avg_out   (avg_out),
    .avg_diff  (avg_diff),
    .avg_valid (avg_valid)
);

// File: tb/tb_phase_capture_avg.sv
module tb_phase_capture_avg;
    localparam int CW    = 8;
    localparam int DEPTH = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic [CW-1:0] reload_val = 8'd37;
    logic ref_in = 1'b0;
    logic hc_tick = 1'b0;
    logic rec_en = 1'b0;
    logic act_stb = 1'b0;
    logic [CW-1:0] phase_cap;
    logic [CW-1:0] avg_out;
    logic signed [CW:0] avg_diff;
    logic avg_valid;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    int m_lim = 0;
    int hist [DEPTH];
    int hptr = 0;
    int prev_exp = 0;
    int lcg = 7;
    int valid_seen = 0;

    always #5 clk = ~clk;

    phase_capture_avg #(.CNT_W(CW), .HIST_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .run(run), .reload_val(reload_val),
        .ref_in(ref_in), .hc_tick(hc_tick), .rec_en(rec_en), .act_stb(act_stb),
        .phase_cap(phase_cap), .avg_out(avg_out), .avg_diff(avg_diff),
        .avg_valid(avg_valid)
    );

    // independent counter model built from R2
    always @(posedge clk) begin
        if (rst || !run) begin
            m_cnt <= 0;
            m_lim <= int'(reload_val);
        end else if (m_cnt == m_lim) begin
            m_cnt <= 0;
            m_lim <= int'(reload_val);
        end else begin
            m_cnt <= m_cnt + 1;
        end
    end

    always @(posedge clk) if (avg_valid) valid_seen <= valid_seen + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic toggle_ref(input int gap);
        int expv;
        repeat (gap) @(negedge clk);
        ref_in = ~ref_in;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        expv = m_cnt;
        @(negedge clk);
        check("R3 capture", int'(phase_cap), expv);
    endtask

    task automatic tick(input logic en);
        @(negedge clk);
        rec_en = en;
        hc_tick = 1'b1;
        if (en) begin
            hist[hptr] = int'(phase_cap);
            hptr = (hptr == DEPTH - 1) ? 0 : hptr + 1;
        end
        @(negedge clk);
        hc_tick = 1'b0;
        rec_en = 1'b0;
    endtask

    task automatic action(input string req);
        int s;
        int expv;
        int w;
        s = 0;
        for (int i = 0; i < DEPTH; i++) s += hist[i];
        expv = s / DEPTH;
        @(negedge clk);
        act_stb = 1'b1;
        @(negedge clk);
        act_stb = 1'b0;
        w = 0;
        while (!avg_valid && w < 100) begin
            @(negedge clk);
            w++;
        end
        check({req, " valid"}, int'(avg_valid), 1);
        check({req, " avg R5"}, int'(avg_out), expv);
        check({req, " diff R6"}, int'(avg_diff), expv - prev_exp);
        prev_exp = expv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cap", int'(phase_cap), 0);
        check("R1 avg", int'(avg_out), 0);
        check("R1 diff", int'(avg_diff), 0);
        check("R1 valid", int'(avg_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", int'(avg_out), 0);
        action("R1 empty history");

        // R2/R3: capture sweep over many spacings, reload changed mid-run
        run = 1'b1;
        for (int k = 0; k < 30; k++) begin
            lcg = (lcg * 37 + 11) % 101;
            if (k == 12) reload_val = 8'd20;
            if (k == 22) reload_val = 8'd63;
            toggle_ref(lcg % 45);
        end

        // R4/R5/R6: fill past the depth so the oldest entries drop out
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < DEPTH + 3 + r; k++) begin
                lcg = (lcg * 29 + 5) % 97;
                toggle_ref(lcg % 31);
                tick(1'b1);
            end
            action("R4 wrap round");
        end

        // R4: ticks with recording disabled change nothing
        for (int k = 0; k < 6; k++) begin
            toggle_ref(k * 3 + 1);
            tick(1'b0);
        end
        action("R4 rec_en low");
        check("R4 ignored diff", int'(avg_diff), 0);

        // R7: repeated strobe during a division
        toggle_ref(4);
        tick(1'b1);
        valid_seen = 0;
        @(negedge clk);
        act_stb = 1'b1;
        @(negedge clk);
        act_stb = 1'b0;
        repeat (3) @(negedge clk);
        act_stb = 1'b1;
        @(negedge clk);
        act_stb = 1'b0;
        repeat (60) @(negedge clk);
        check("R7 single valid", valid_seen, 1);
        begin
            int s;
            s = 0;
            for (int i = 0; i < DEPTH; i++) s += hist[i];
            check("R7 avg R5", int'(avg_out), s / DEPTH);
            check("R7 diff R6", int'(avg_diff), s / DEPTH - prev_exp);
            prev_exp = s / DEPTH;
        end

        // R2: stopping holds the count at zero, so captures read zero
        run = 1'b0;
        toggle_ref(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule